// File: doc/BRIEF.md
# Interlocked Watchdog Timer Controller

This block is a watchdog timer programmed through a small byte-wide register port. Software loads a reload value and a warning threshold, then sets a run bit. From then on a counter counts down once per clock. Periodic service writes, or kicks, restart the countdown. When the count passes the warning threshold, a warning output rises. Depending on a configuration bit, a discrete output rises with it. If the count reaches zero, the block issues a one-cycle reset request, reloads and keeps running.

A configuration register selects an interlock policy that governs whether a running watchdog may be stopped. The watchdog can be stopped freely, or only while an external permission input is high, or not at all until reset. While the watchdog runs, the configuration register is frozen, so the policy cannot be relaxed by software once armed.

Register map (byte addresses): 0 configuration, 1 control, 2 kick, 3 and 4 reload low and high byte, 5 and 6 warning threshold low and high byte. Read data is registered and appears one cycle after the address is presented. Other addresses read as zero.

Top module: `wdt_ctl`

## Requirements
- R1: The configuration register at address 0 holds the interlock code in bits 5:4 and the warning-to-discrete enable in bit 1. All other bits read 0, whatever value is written. Its value after reset is 0x12 (code 01, enable 1).
- R2: Writes to the configuration register have no effect while the watchdog is running.
- R3: With interlock code 00, writing 0 to bit 0 of the control register (address 1) stops a running watchdog.
- R4: With interlock code 01, a stop write is honoured only when perm_in is high. While perm_in is low, the watchdog keeps running.
- R5: With interlock code 10 or 11, once started the watchdog cannot be stopped by any write until reset.
- R6: Writing 1 to control bit 0 while stopped starts the countdown from the reload value (little-endian bytes at addresses 3 and 4). Control bit 0 reads 1 while running. Writing 1 while running has no effect. Reload and threshold bytes read back as written.
- R7: The start edge is E0. warn_out rises after edge E(reload−threshold+1). reset_req is high for exactly one cycle after edge E(reload+1). The timeout clears warn_out, reloads the count and leaves the watchdog running.
- R8: discrete_out rises together with warn_out when configuration bit 1 is set, and stays low when it is clear.
- R9: A write to address 2 while running reloads the count and clears warn_out and discrete_out. A kick on the same edge where the count is at zero suppresses the reset request. A kick on the same edge where the count equals the threshold suppresses the warning. A kick while stopped has no effect.
- R10: After reset the watchdog is stopped and warn_out, discrete_out and reset_req are low. A permitted stop clears warn_out and discrete_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| perm_in | input | 1 | Stop permission input used by interlock code 01 |
| warn_out | output | 1 | Warning stage active |
| discrete_out | output | 1 | Warning copy to the external discrete, when enabled |
| reset_req | output | 1 | One-cycle timeout reset request |

## Verification
Two functions can land on the same clock edge: a kick write, and the counter reaching zero or reaching the warning threshold. The bench places a kick exactly on the edge where the count reaches zero, and also exactly on the threshold edge, by counting edges from the start write. It then judges that no reset request or warning appeared and that the next timeout comes a full reload period after the kick. A behavioural reference model, updated from the same stimulus, is compared against every output on every clock, which also covers a stop write competing with an in-flight warning.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_GPIO = 2'b01,
    LOCK_HARD = 2'b10,
    LOCK_RSVD = 2'b11
  } lock_mode_e;

  typedef struct packed {
    lock_mode_e mode;
    logic       disc_en;
  } cfg_t;

  localparam int unsigned A_CFG    = 0;
  localparam int unsigned A_CTRL   = 1;
  localparam int unsigned A_KICK   = 2;
  localparam int unsigned A_RELOAD = 3;

  localparam logic [7:0] CFG_MASK  = 8'h32;
  localparam logic [7:0] CFG_RESET = 8'h12;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD_DEF = '1,
  parameter logic [CNT_W-1:0] THRESH_DEF = CNT_W'(256)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              running,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  thresh,
  output logic [7:0]        rdata
);

  localparam int NB       = CNT_W / 8;
  localparam int THR_BASE = A_RELOAD + NB;

  logic [7:0]         cfg_q;
  logic [NB-1:0][7:0] rld_q;
  logic [NB-1:0][7:0] thr_q;
  logic               cfg_wr;
  logic [7:0]         rd_next;

  // configuration is frozen while the counter runs
  assign cfg_wr = we && (addr == ADDR_W'(A_CFG)) && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_wr) begin
      cfg_q <= wdata & CFG_MASK;
    end
  end

  assign cfg.mode    = lock_mode_e'(cfg_q[5:4]);
  assign cfg.disc_en = cfg_q[1];

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] rld_b;
    logic [7:0] thr_b;
    always_ff @(posedge clk) begin
      if (rst) begin
        rld_b <= RELOAD_DEF[b*8 +: 8];
        thr_b <= THRESH_DEF[b*8 +: 8];
      end else if (we) begin
        if (addr == ADDR_W'(A_RELOAD + b)) rld_b <= wdata;
        if (addr == ADDR_W'(THR_BASE + b)) thr_b <= wdata;
      end
    end
    assign rld_q[b] = rld_b;
    assign thr_q[b] = thr_b;
  end

  assign reload = rld_q;
  assign thresh = thr_q;

  always_comb begin
    rd_next = 8'h00;
    if (addr == ADDR_W'(A_CFG))  rd_next = cfg_q;
    if (addr == ADDR_W'(A_CTRL)) rd_next = {7'b0, running};
    for (int b = 0; b < NB; b++) begin
      if (addr == ADDR_W'(A_RELOAD + b)) rd_next = rld_q[b];
      if (addr == ADDR_W'(THR_BASE + b)) rd_next = thr_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_next;
  end

  // R1: reserved configuration bits never read back as one
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_W'(A_CFG)) |-> ((rdata & ~CFG_MASK) == 8'h00))
    else $error("reserved configuration bit read as one");

  // R2: configuration holds its value across a running cycle
  assert_cfg_lock_R2: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(cfg_q))
    else $error("configuration changed while running");

endmodule

// File: rtl/wdt_interlock.sv
module wdt_interlock import wdt_pkg::*; (
  input  lock_mode_e mode,
  input  logic       perm,
  output logic       allow
);

  always_comb begin
    unique case (mode)
      LOCK_NONE: allow = 1'b1;
      LOCK_GPIO: allow = perm;
      default:   allow = 1'b0;   // hard lock and the reserved code
    endcase
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop_ok,
  input  logic             kick,
  input  logic             disc_en,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] thresh,
  output logic             running,
  output logic             warn,
  output logic             disc,
  output logic             timeout
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt_q   <= '0;
      warn    <= 1'b0;
      disc    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          cnt_q   <= reload;
          warn    <= 1'b0;
          disc    <= 1'b0;
        end
      end else if (stop_ok) begin
        running <= 1'b0;
        warn    <= 1'b0;
        disc    <= 1'b0;
      end else if (kick) begin
        cnt_q <= reload;
        warn  <= 1'b0;
        disc  <= 1'b0;
      end else if (cnt_q == '0) begin
        timeout <= 1'b1;
        cnt_q   <= reload;
        warn    <= 1'b0;
        disc    <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == thresh) begin
          warn <= 1'b1;
          disc <= disc_en;
        end
      end
    end
  end

  // R7: a timeout request only comes from a running watchdog
  assert_timeout_running_R7: assert property (@(posedge clk) disable iff (rst)
    timeout |-> running)
    else $error("timeout while stopped");

  // R8: the discrete never leads the warning
  assert_disc_warn_R8: assert property (@(posedge clk) disable iff (rst)
    disc |-> warn)
    else $error("discrete without warning");

  // R9: a service write leaves neither warning nor timeout behind
  assert_kick_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (running && kick && !stop_ok) |=> (!warn && !timeout))
    else $error("kick did not clear warning stage");

  // R10: the warning is dropped whenever the watchdog is stopped
  assert_warn_run_R10: assert property (@(posedge clk) disable iff (rst)
    warn |-> running)
    else $error("warning while stopped");

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl import wdt_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD_DEF = '1,
  parameter logic [CNT_W-1:0] THRESH_DEF = CNT_W'(256)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              perm_in,
  output logic              warn_out,
  output logic              discrete_out,
  output logic              reset_req
);

  cfg_t             cfg;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] thresh;
  logic             running;
  logic             ctrl_wr;
  logic             start;
  logic             stop_req;
  logic             stop_ok;
  logic             allow;
  logic             kick;

  assign ctrl_wr  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign start    = ctrl_wr && reg_wdata[0];
  assign stop_req = ctrl_wr && !reg_wdata[0];
  assign stop_ok  = stop_req && allow;
  assign kick     = reg_we && (reg_addr == ADDR_W'(A_KICK));

  wdt_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .RELOAD_DEF(RELOAD_DEF), .THRESH_DEF(THRESH_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .running(running), .cfg(cfg), .reload(reload), .thresh(thresh),
    .rdata(reg_rdata)
  );

  wdt_interlock u_lock (
    .mode(cfg.mode), .perm(perm_in), .allow(allow)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .stop_ok(stop_ok), .kick(kick),
    .disc_en(cfg.disc_en), .reload(reload), .thresh(thresh),
    .running(running), .warn(warn_out), .disc(discrete_out),
    .timeout(reset_req)
  );

  // R3: free mode obeys a stop write
  assert_free_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (running && cfg.mode == LOCK_NONE && stop_req) |=> !running)
    else $error("stop refused in free mode");

  // R4: permission-gated mode keeps running while permission is low
  assert_gpio_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (running && cfg.mode == LOCK_GPIO && !perm_in) |=> running)
    else $error("stopped without permission");

  // R5: hard and reserved codes never stop once running
  assert_hard_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (running && cfg.mode[1]) |=> running)
    else $error("hard-locked watchdog stopped");

endmodule

// File: tb/sim_wdt_ctl.sv
module sim_wdt_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       perm_in = 1'b0;
  logic [7:0] reg_rdata;
  logic       warn_out, discrete_out, reset_req;

  always #2 clk = ~clk;   // 250 MHz

  wdt_ctl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .perm_in(perm_in),
    .warn_out(warn_out), .discrete_out(discrete_out), .reset_req(reset_req)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string phase  = "R10";

  // behavioural reference state
  int m_cfg, m_rld, m_thr, m_cnt, m_rd;
  bit m_run, m_warn, m_disc, m_to;
  int a, nrd, mode;
  bit was_run, st, dis, kk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
    if (rst) begin
      m_cfg = 'h12; m_rld = 'hFFFF; m_thr = 'h0100; m_cnt = 0; m_rd = 0;
      m_run = 0; m_warn = 0; m_disc = 0; m_to = 0;
    end else begin
      a = int'(reg_addr);
      case (a)
        0: nrd = m_cfg;
        1: nrd = int'(m_run);
        3: nrd = m_rld % 256;
        4: nrd = m_rld / 256;
        5: nrd = m_thr % 256;
        6: nrd = m_thr / 256;
        default: nrd = 0;
      endcase
      mode    = (m_cfg / 16) % 4;
      was_run = m_run;
      st  = reg_we && a == 1 && reg_wdata[0];
      dis = reg_we && a == 1 && !reg_wdata[0] &&
            (mode == 0 || (mode == 1 && perm_in));
      kk  = reg_we && a == 2;
      m_to = 0;
      if (!was_run) begin
        if (st) begin m_run = 1; m_cnt = m_rld; m_warn = 0; end
      end else if (dis) begin
        m_run = 0; m_warn = 0;
      end else if (kk) begin
        m_cnt = m_rld; m_warn = 0;
      end else if (m_cnt == 0) begin
        m_to = 1; m_cnt = m_rld; m_warn = 0;
      end else begin
        if (m_cnt == m_thr) m_warn = 1;
        m_cnt = m_cnt - 1;
      end
      m_disc = m_warn && ((m_cfg / 2) % 2 == 1);
      if (reg_we) begin
        case (a)
          0: if (!was_run) m_cfg = int'(reg_wdata) & 'h32;
          3: m_rld = (m_rld / 256) * 256 + int'(reg_wdata);
          4: m_rld = (m_rld % 256) + int'(reg_wdata) * 256;
          5: m_thr = (m_thr / 256) * 256 + int'(reg_wdata);
          6: m_thr = (m_thr % 256) + int'(reg_wdata) * 256;
          default: ;
        endcase
      end
      m_rd = nrd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk({phase, " model warn_out"}, int'(warn_out), int'(m_warn));
      chk({phase, " model discrete_out"}, int'(discrete_out), int'(m_disc));
      chk({phase, " model reset_req"}, int'(reset_req), int'(m_to));
      chk({phase, " model reg_rdata"}, int'(reg_rdata), m_rd);
    end
  end

  task automatic wr(input int ad, input int d);
    reg_addr  = ad[3:0];
    reg_wdata = d[7:0];
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int ad, input int exp, input string tag);
    reg_addr = ad[3:0];
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    phase = "R10";
    chk("R10 warn after reset", int'(warn_out), 0);
    chk("R10 discrete after reset", int'(discrete_out), 0);
    chk("R10 reset_req after reset", int'(reset_req), 0);
    rd(0, 'h12, "R1 configuration reset value");
    rd(1, 0, "R10 stopped after reset");

    phase = "R1";
    wr(0, 'hFF);
    rd(0, 'h32, "R1 reserved bits read zero");
    wr(0, 'h02);
    rd(0, 'h02, "R1 code 00 with discrete enable");

    phase = "R6";
    wr(3, 20); wr(4, 0); wr(5, 5); wr(6, 0);
    rd(3, 20, "R6 reload low byte");
    rd(5, 5, "R6 threshold low byte");
    rd(6, 0, "R6 threshold high byte");

    phase = "R7";
    wr(1, 1);                    // start edge E0
    idle(15);
    chk("R7 no warning before threshold", int'(warn_out), 0);
    idle(1);
    chk("R7 warning after threshold", int'(warn_out), 1);
    chk("R8 discrete follows warning", int'(discrete_out), 1);
    idle(4);
    chk("R7 no timeout early", int'(reset_req), 0);
    idle(1);
    chk("R7 timeout pulse", int'(reset_req), 1);
    chk("R7 timeout clears warning", int'(warn_out), 0);
    idle(1);
    chk("R7 pulse lasts one cycle", int'(reset_req), 0);
    rd(1, 1, "R7 running after timeout");

    phase = "R2";
    wr(0, 'h20);
    rd(0, 'h02, "R2 configuration locked while running");

    phase = "R10";
    wr(2, 0);
    idle(16);
    chk("R10 warning up before stop", int'(warn_out), 1);
    phase = "R3";
    wr(1, 0);
    chk("R10 permitted stop clears warning", int'(warn_out), 0);
    chk("R10 permitted stop clears discrete", int'(discrete_out), 0);
    rd(1, 0, "R3 code 00 stop honoured");

    phase = "R9";
    wr(2, 0);
    rd(1, 0, "R9 kick while stopped ignored");
    chk("R9 no warning from idle kick", int'(warn_out), 0);
    wr(1, 1);
    idle(20);
    wr(2, 0);                    // same edge as count at zero
    chk("R9 kick at zero suppresses timeout", int'(reset_req), 0);
    chk("R9 kick clears warning", int'(warn_out), 0);
    idle(20);
    chk("R9 no timeout before full period", int'(reset_req), 0);
    idle(1);
    chk("R9 timeout a full period after kick", int'(reset_req), 1);
    wr(2, 0);
    idle(15);
    wr(2, 0);                    // same edge as count at threshold
    chk("R9 kick at threshold suppresses warning", int'(warn_out), 0);
    for (int i = 0; i < 6; i++) begin
      idle(10);
      wr(2, 0);
      chk("R9 serviced watchdog never times out", int'(reset_req), 0);
    end
    wr(1, 0);

    phase = "R8";
    wr(0, 'h00);
    wr(1, 1);
    idle(16);
    chk("R8 warning with discrete disabled", int'(warn_out), 1);
    chk("R8 discrete stays low when disabled", int'(discrete_out), 0);
    wr(1, 0);

    phase = "R6";
    wr(1, 1);                    // E0
    idle(5);
    wr(1, 1);                    // E6, must not restart
    idle(14);
    chk("R6 repeated start no early timeout", int'(reset_req), 0);
    idle(1);
    chk("R6 repeated start keeps original schedule", int'(reset_req), 1);
    wr(1, 0);

    phase = "R4";
    wr(0, 'h12);
    rd(0, 'h12, "R4 code 01 configured");
    wr(1, 1);
    perm_in = 1'b0;
    wr(1, 0);
    rd(1, 1, "R4 stop refused while permission low");
    perm_in = 1'b1;
    wr(1, 0);
    rd(1, 0, "R4 stop honoured while permission high");
    perm_in = 1'b0;

    phase = "R5";
    wr(0, 'h22);
    wr(1, 1);
    perm_in = 1'b1;
    wr(1, 0);
    rd(1, 1, "R5 code 10 cannot stop");
    wr(0, 'h00);
    rd(0, 'h22, "R2 configuration locked in code 10");
    do_reset();
    rd(0, 'h12, "R10 configuration default after reset");
    rd(1, 0, "R10 stopped after second reset");
    wr(0, 'h32);
    rd(0, 'h32, "R5 code 11 configured");
    wr(1, 1);
    wr(1, 0);
    rd(1, 1, "R5 code 11 cannot stop with permission");
    perm_in = 1'b0;
    wr(1, 0);
    rd(1, 1, "R5 code 11 cannot stop without permission");
    do_reset();

    summary();
    $finish;
  end

endmodule